// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous Burst SRAM

This block is the control front end of a pipelined synchronous burst SRAM. On every rising clock edge it samples three chip enables, two address strobes (a processor strobe and a controller strobe), an advance input, the write controls (global write, byte-write enable and per-byte selects), a burst-order select and the external address. From these it classifies the cycle as a deselect, the start of a burst at the external address, a step to the next burst address, or a hold at the current one.

The block owns the address register and a two-bit burst offset counter. It gives the array datapath a word address, a command-valid flag, a read/write flag with byte enables, a flag that marks the first write beat of an access, and a selected flag. All command outputs are registered: a decision taken at edge N is visible from just after edge N until edge N+1. The two strobes differ in priority, in how the first chip enable masks them, and in when a write is decided. A processor-strobe access always starts as a read. Its write controls are looked at only one edge later. A controller-strobe write is decided on the edge that loads the address. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain level that is sampled at the clock edge.

Top module: `burst_seq_ctrl`

## Requirements
- R1: The device counts as enabled only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A recognised strobe on an edge where it is not enabled deselects the block: after that edge `selected`, `cmd_valid`, `cmd_write` and `wr_first` are 0. While `selected` is 1, `cmd_valid` is 1.
- R2: When both strobes are low and the device is enabled, only the processor strobe acts. The access starts as a read of the loaded address, whatever the write controls are on that edge.
- R3: The processor strobe is ignored while `ce1_n` is 1. If the controller strobe is high on such an edge, a running burst goes on as if no strobe were present.
- R4: An accepted strobe loads the full external address. After that edge `word_addr` equals the sampled `addr`, and its two low bits are the burst start value.
- R5: After a processor-strobe start, the write controls on the next edge decide the access. If they request a write, that edge issues a write to the same address with `wr_first`=1, and advance is not applied. Otherwise the burst proceeds by the advance rule.
- R6: A controller-strobe start with the processor strobe high issues its write on the same edge, using the write controls sampled there. Advance is ignored on that edge.
- R7: A write is requested when `gw_n`=0, which enables all bytes. It is also requested when `bwe_n`=0 and at least one `bw_n[i]`=0, which enables byte lane i. `cmd_be` bit i is set for each enabled lane. With no write requested, the command is a read with `cmd_be`=0.
- R8: With both strobes high on a selected cycle, `adv_n`=0 moves to the next burst address and `adv_n`=1 keeps the current one. This holds for reads and for writes.
- R9: With `order_sel`=1 the burst is interleaved: on beat k the low two bits are the start value XOR k.
- R10: With `order_sel`=0 the burst is linear: on beat k the low two bits are (start + k) mod 4.
- R11: The bits of `word_addr` above bit 1 never change during a burst. After four beats the offset wraps back to the start value.
- R12: After reset `selected`, `cmd_valid`, `cmd_write`, `wr_first` and `cmd_be` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ce1_n | input | 1 | Chip enable 1, active low; also masks the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| strb_proc_n | input | 1 | Processor address strobe, active low, higher priority |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NBYTE | Per-byte write selects, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| addr | input | AW | External word address |
| word_addr | output | AW | Array word address of the current beat |
| cmd_valid | output | 1 | An access is issued this cycle |
| cmd_write | output | 1 | The access is a write |
| cmd_be | output | NBYTE | Byte enables of a write |
| wr_first | output | 1 | First write beat of an access |
| selected | output | 1 | The device is selected |

## Verification
On every cycle, the assertions check the following: deselect after an enable-masked strobe, processor-strobe priority with its first cycle forced to a read, a same-edge controller write, address hold on suspend, the upper address bits staying stable inside a burst, and a processor strobe masked by the first chip enable keeping the burst alive. The exact burst sequences need the bench's reference model, run for every start value in both orders and across wrap-around. So do the two-edge processor write, the byte-lane mapping and the mixed random traffic.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_DESEL = 2'd1,
    EV_LOADP = 2'd2,
    EV_LOADC = 2'd3
  } edge_ev_t;

  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       interleave);
    beat_low = interleave ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/bseq_strobe_decode.sv
module bseq_strobe_decode
  import bseq_pkg::*;
(
  input  logic     ce1_n,
  input  logic     ce2,
  input  logic     ce3_n,
  input  logic     strb_proc_n,
  input  logic     strb_ctrl_n,
  output edge_ev_t ev
);
  logic enabled;
  logic proc_seen;
  logic ctrl_seen;

  always_comb begin
    enabled   = !ce1_n && ce2 && !ce3_n;
    proc_seen = !strb_proc_n && !ce1_n;
    ctrl_seen = !strb_ctrl_n;
    if ((proc_seen || ctrl_seen) && !enabled) ev = EV_DESEL;
    else if (proc_seen)                       ev = EV_LOADP;
    else if (ctrl_seen)                       ev = EV_LOADC;
    else                                      ev = EV_NONE;
  end
endmodule

// File: rtl/bseq_write_mask.sv
module bseq_write_mask #(
  parameter int NBYTE = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [NBYTE-1:0] bw_n,
  output logic [NBYTE-1:0] lane_en,
  output logic             wr_req
);
  for (genvar i = 0; i < NBYTE; i++) begin : g_lane
    assign lane_en[i] = !gw_n || (!bwe_n && !bw_n[i]);
  end
  assign wr_req = |lane_en;
endmodule

// File: rtl/bseq_burst_addr.sv
module bseq_burst_addr
  import bseq_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          interleave,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] word_addr
);
  localparam int OFFW = 2;

  logic [AW-1:0]   base_q;
  logic [OFFW-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= ext_addr;
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign word_addr = {base_q[AW-1:OFFW], beat_low(base_q[OFFW-1:0], beat_q, interleave)};
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import bseq_pkg::*;
#(
  parameter int AW    = 17,
  parameter int NBYTE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             strb_proc_n,
  input  logic             strb_ctrl_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [NBYTE-1:0] bw_n,
  input  logic             order_sel,
  input  logic [AW-1:0]    addr,
  output logic [AW-1:0]    word_addr,
  output logic             cmd_valid,
  output logic             cmd_write,
  output logic [NBYTE-1:0] cmd_be,
  output logic             wr_first,
  output logic             selected
);
  edge_ev_t         ev;
  logic [NBYTE-1:0] lane_en;
  logic             wr_req;
  logic             pend_q;
  logic             load;
  logic             step;
  logic             late_wr;

  bseq_strobe_decode u_dec (
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .ev(ev)
  );

  bseq_write_mask #(.NBYTE(NBYTE)) u_wm (
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .lane_en(lane_en), .wr_req(wr_req)
  );

  // a processor-strobe write lands one edge after the load
  assign late_wr = pend_q && wr_req;
  assign load    = (ev == EV_LOADP) || (ev == EV_LOADC);
  assign step    = (ev == EV_NONE) && selected && !late_wr && !adv_n;

  bseq_burst_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .interleave(order_sel), .ext_addr(addr), .word_addr(word_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected  <= 1'b0;
      pend_q    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_write <= 1'b0;
      cmd_be    <= '0;
      wr_first  <= 1'b0;
    end else begin
      unique case (ev)
        EV_DESEL: begin
          selected  <= 1'b0;
          pend_q    <= 1'b0;
          cmd_valid <= 1'b0;
          cmd_write <= 1'b0;
          cmd_be    <= '0;
          wr_first  <= 1'b0;
        end
        EV_LOADP: begin
          selected  <= 1'b1;
          pend_q    <= 1'b1;
          cmd_valid <= 1'b1;
          cmd_write <= 1'b0;
          cmd_be    <= '0;
          wr_first  <= 1'b0;
        end
        EV_LOADC: begin
          selected  <= 1'b1;
          pend_q    <= 1'b0;
          cmd_valid <= 1'b1;
          cmd_write <= wr_req;
          cmd_be    <= lane_en;
          wr_first  <= wr_req;
        end
        default: begin
          pend_q    <= 1'b0;
          cmd_valid <= selected;
          cmd_write <= selected && wr_req;
          cmd_be    <= selected ? lane_en : '0;
          wr_first  <= selected && late_wr;
        end
      endcase
    end
  end
endmodule

// File: rtl/burst_seq_ctrl_chk.sv
module burst_seq_ctrl_chk #(
  parameter int AW    = 17,
  parameter int NBYTE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             strb_proc_n,
  input logic             strb_ctrl_n,
  input logic             adv_n,
  input logic             gw_n,
  input logic [AW-1:0]    addr,
  input logic [AW-1:0]    word_addr,
  input logic             cmd_valid,
  input logic             cmd_write,
  input logic [NBYTE-1:0] cmd_be,
  input logic             selected
);
  logic en_all;
  logic no_strb;
  assign en_all  = !ce1_n && ce2 && !ce3_n;
  assign no_strb = strb_proc_n && strb_ctrl_n;

  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (((!strb_proc_n && !ce1_n) || !strb_ctrl_n) && !en_all) |=> (!selected && !cmd_valid));

  assert_proc_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_proc_n && !strb_ctrl_n && en_all) |=> (word_addr == $past(addr) && !cmd_write && cmd_valid));

  assert_proc_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && !strb_proc_n && strb_ctrl_n && selected) |=> selected);

  assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && !strb_ctrl_n && en_all && !gw_n) |=>
      (cmd_write && word_addr == $past(addr) && cmd_be == {NBYTE{1'b1}}));

  assert_suspend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && no_strb && adv_n) |=> $stable(word_addr));

  assert_upper_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && no_strb) |=> $stable(word_addr[AW-1:2]));
endmodule

bind burst_seq_ctrl burst_seq_ctrl_chk #(.AW(AW), .NBYTE(NBYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
  .gw_n(gw_n), .addr(addr), .word_addr(word_addr), .cmd_valid(cmd_valid),
  .cmd_write(cmd_write), .cmd_be(cmd_be), .selected(selected)
);

// File: tb/tb_burst_seq_ctrl.sv
module tb_burst_seq_ctrl;
  localparam int AW = 17;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [NB-1:0] bw_n = '1;
  logic order_sel = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] word_addr;
  logic cmd_valid, cmd_write, wr_first, selected;
  logic [NB-1:0] cmd_be;

  always #10 clk = ~clk;

  burst_seq_ctrl #(.AW(AW), .NBYTE(NB)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string scen = "R12";

  // reference state
  logic [AW-1:0] m_base = '0;
  int m_beat = 0;
  bit m_sel = 0, m_pend = 0, m_valid = 0, m_write = 0, m_first = 0;
  logic [NB-1:0] m_be = '0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr();
    int lo;
    lo = order_sel ? (int'(m_base[1:0]) ^ m_beat) : ((int'(m_base[1:0]) + m_beat) % 4);
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic compare_all();
    chk("R1 selected", selected, m_sel);
    chk("R1 cmd_valid", cmd_valid, m_valid);
    chk("R6 cmd_write", cmd_write, m_write);
    chk("R7 cmd_be", cmd_be, m_be);
    chk("R5 wr_first", wr_first, m_first);
    if (m_sel) chk(order_sel ? "R9 word_addr" : "R10 word_addr", word_addr, exp_addr());
  endtask

  task automatic model_step();
    bit en, pr, seen, wr;
    logic [NB-1:0] be;
    en   = !ce1_n && ce2 && !ce3_n;
    pr   = !strb_proc_n && !ce1_n;
    seen = pr || !strb_ctrl_n;
    be   = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
    wr   = (be != 0);
    if (seen && !en) begin
      m_sel = 0; m_pend = 0; m_valid = 0; m_write = 0; m_first = 0; m_be = '0;
    end else if (pr) begin
      m_base = addr; m_beat = 0;
      m_sel = 1; m_pend = 1; m_valid = 1; m_write = 0; m_first = 0; m_be = '0;
    end else if (!strb_ctrl_n) begin
      m_base = addr; m_beat = 0;
      m_sel = 1; m_pend = 0; m_valid = 1; m_write = wr; m_first = wr; m_be = be;
    end else if (m_sel) begin
      if (m_pend && wr) begin
        m_write = 1; m_first = 1; m_be = be;
      end else begin
        if (!adv_n) m_beat = (m_beat + 1) % 4;
        m_write = wr; m_first = 0; m_be = be;
      end
      m_pend = 0; m_valid = 1;
    end else begin
      m_valid = 0; m_write = 0; m_first = 0; m_be = '0; m_pend = 0;
    end
  endtask

  task automatic cyc(input bit c1, input bit c2, input bit c3, input bit sp, input bit sc,
                     input bit av, input bit g, input bit bwe, input logic [NB-1:0] bw,
                     input logic [AW-1:0] a);
    @(negedge clk);
    compare_all();
    ce1_n = c1; ce2 = c2; ce3_n = c3; strb_proc_n = sp; strb_ctrl_n = sc;
    adv_n = av; gw_n = g; bwe_n = bwe; bw_n = bw; addr = a;
    model_step();
  endtask

  // enabled, no strobe, reads, advance level given
  task automatic idle_adv(input bit av);
    cyc(0, 1, 0, 1, 1, av, 1, 1, '1, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    scen = "R12";
    chk("R12 selected", selected, 0);
    chk("R12 cmd_valid", cmd_valid, 0);
    chk("R12 cmd_write", cmd_write, 0);
    chk("R12 wr_first", wr_first, 0);
    chk("R12 cmd_be", cmd_be, 0);
    rst_n = 1'b1;

    // R9 R10 R11: every start value, both orders, five beats to see the wrap
    for (int md = 1; md >= 0; md--) begin
      cyc(1, 0, 1, 1, 1, 1, 1, 1, '1, '0);
      order_sel = md[0];
      for (int s = 0; s < 4; s++) begin
        scen = md ? "R9 R11 interleaved" : "R10 R11 linear";
        cyc(0, 1, 0, 1, 0, 1, 1, 1, '1, AW'(17'h1abc0 | s));
        for (int k = 0; k < 5; k++) idle_adv(0);
      end
    end

    // R8: suspend then continue on a write burst
    scen = "R8 suspend";
    cyc(0, 1, 0, 1, 0, 0, 0, 1, '1, 17'h00042);
    cyc(0, 1, 0, 1, 1, 1, 0, 1, '1, '0);
    cyc(0, 1, 0, 1, 1, 1, 0, 1, '1, '0);
    cyc(0, 1, 0, 1, 1, 0, 0, 1, '1, '0);
    idle_adv(1);

    // R5: processor write, decided on the second edge
    scen = "R5 proc write";
    cyc(0, 1, 0, 0, 1, 0, 0, 0, 4'b0000, 17'h05555);
    cyc(0, 1, 0, 1, 1, 0, 1, 0, 4'b1010, '0);
    cyc(0, 1, 0, 1, 1, 0, 1, 0, 4'b1010, '0);
    scen = "R5 proc read";
    cyc(0, 1, 0, 0, 1, 1, 1, 1, '1, 17'h0777e);
    idle_adv(0);
    idle_adv(0);

    // R2: both strobes with write controls active
    scen = "R2 both strobes";
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 4'b0000, 17'h12343);
    cyc(0, 1, 0, 1, 1, 1, 1, 1, '1, '0);

    // R6 R7: controller writes with several lane patterns
    scen = "R6 R7 ctrl write";
    cyc(0, 1, 0, 1, 0, 0, 1, 0, 4'b1110, 17'h00101);
    cyc(0, 1, 0, 1, 0, 0, 1, 0, 4'b0101, 17'h00202);
    cyc(0, 1, 0, 1, 0, 0, 1, 0, 4'b1111, 17'h00303);
    cyc(0, 1, 0, 1, 0, 0, 1, 1, 4'b0000, 17'h00404);
    cyc(0, 1, 0, 1, 0, 0, 0, 1, 4'b1111, 17'h00505);

    // R3: processor strobe masked by ce1, burst keeps going
    scen = "R3 ce1 mask";
    cyc(1, 1, 0, 0, 1, 0, 1, 1, '1, 17'h1ffff);
    cyc(1, 1, 0, 0, 1, 1, 1, 1, '1, 17'h1ffff);

    // R1: deselect through each enable
    scen = "R1 ce2 low";
    cyc(0, 0, 0, 1, 0, 1, 1, 1, '1, 17'h00001);
    idle_adv(0);
    scen = "R1 ce3 high";
    cyc(0, 1, 0, 1, 0, 1, 1, 1, '1, 17'h00002);
    cyc(0, 1, 1, 0, 1, 1, 1, 1, '1, 17'h00003);
    scen = "R1 ce1 high ctrl";
    cyc(0, 1, 0, 1, 0, 1, 1, 1, '1, 17'h00004);
    cyc(1, 1, 0, 1, 0, 1, 1, 1, '1, 17'h00005);
    idle_adv(0);

    // R4 and mixed traffic
    scen = "R4 random";
    for (int i = 0; i < 3000; i++) begin
      bit c1, c2, c3, sp, sc;
      int r;
      r  = $urandom % 16;
      c1 = (r == 0); c2 = (r != 1); c3 = (r == 2);
      sp = ($urandom % 6) != 0;
      sc = ($urandom % 5) != 0;
      if (i == 1500) begin
        cyc(1, 0, 1, 1, 0, 1, 1, 1, '1, '0);
        order_sel = 1'b0;
      end
      cyc(c1, c2, c3, sp, sc, 1'($urandom), 1'(($urandom % 4) != 0),
          1'($urandom), NB'($urandom), AW'($urandom));
    end
    idle_adv(1);
    @(negedge clk);
    compare_all();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule